// File: doc/BRIEF.md
# SDRAM Bank Legality Tracker

This block sits beside the command issue stage of a multi-bank SDRAM controller. It watches the single command/address bus, where at most one command (precharge, activate, read or write) appears per cycle, and keeps a legality model of the device. For every bank it records whether the bank is idle (precharged) or active (a row latched in its row buffer), which row is open, and how many cycles the bank stays occupied after a row or precharge operation. It also records the direction of the last column access, so that a read directly after a write, or a write directly after a read, is refused until one idle bus cycle has passed.

The scheduler uses the per-bank legality vectors to pick its next command. The block raises a one-cycle error strobe when a command is issued that the vectors did not allow, and discards that command without touching any bank. A read-data-valid strobe marks the cycle in which the device drives the data of each accepted read.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank is idle and free: `can_act` is all ones, `can_pre`, `can_rd`, `can_wr`, `bank_active` are all zero, and `rd_valid` and `cmd_err` are low.
- R2: An activate (`cmd_op` = 1) is accepted only for an idle, free bank; it makes the bank active and shows the new row on that bank's 12-bit slice of `bank_row` (bank b at bits 12*b+11 down to 12*b).
- R3: After an activate accepted in cycle c, that bank allows no command in cycles c+1 and c+2, and allows read and write in cycle c+3.
- R4: A precharge (`cmd_op` = 0) is accepted only for an active, free bank; in cycle c+1 the bank is idle, it allows nothing in cycles c+1 and c+2, and allows activate in cycle c+3. A precharge to an idle bank is illegal.
- R5: While one bank is occupied, the legality of the other banks is unchanged.
- R6: Reads (`cmd_op` = 2) or writes (`cmd_op` = 3) in the same direction to an active, free bank are accepted in consecutive cycles.
- R7: A column access whose direction differs from an accepted column access in the previous cycle is illegal; after one cycle without an accepted column access either direction is legal.
- R8: For a read accepted in cycle c, `rd_valid` is high in cycle c+3, once per read, and never otherwise.
- R9: A command issued while its legality flag is low raises `cmd_err` during the next cycle only, and leaves `bank_active`, `bank_row` and all occupancy unchanged.
- R10: A read or write accepted with `cmd_autopre` high makes the bank idle and occupied for cycles c+1 to c+3; activate becomes legal in cycle c+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is on the bus this cycle |
| cmd_op | input | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| cmd_bank | input | 2 | Target bank |
| cmd_row | input | 12 | Row for an activate |
| cmd_autopre | input | 1 | Column access closes the bank afterwards |
| can_act | output | 4 | Per bank: activate legal this cycle |
| can_pre | output | 4 | Per bank: precharge legal this cycle |
| can_rd | output | 4 | Per bank: read legal this cycle |
| can_wr | output | 4 | Per bank: write legal this cycle |
| bank_active | output | 4 | Per bank: a row is open |
| bank_row | output | 48 | Open row of each bank, 12 bits per bank |
| rd_valid | output | 1 | Read data is on the pins this cycle |
| cmd_err | output | 1 | The previous cycle's command was illegal |

## Verification
A wrong bank state or open row appears on `bank_active` and `bank_row` one cycle after the command that caused it, and a wrong occupancy count shows as a legality flag that opens one cycle early or late relative to c+3 or c+4. A lost turnaround record shows as a wrong `can_rd` or `can_wr` in the single cycle after a column access, while a mistimed read pipeline shifts `rd_valid` away from c+3, which the scoreboard pins to an exact cycle. Illegal commands are followed by a look at the state outputs to prove nothing moved.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [1:0] {
    OP_PRE = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } sbt_op_e;

  // Occupancy loaded into a bank counter when a command is accepted.
  // A count of N keeps the bank closed for the next N cycles.
  function automatic int unsigned occupancy(input sbt_op_e op, input logic ap,
                                            input int unsigned t_act,
                                            input int unsigned t_pre);
    case (op)
      OP_ACT:  occupancy = t_act - 1;
      OP_PRE:  occupancy = t_pre - 1;
      default: occupancy = ap ? t_pre : 0;
    endcase
  endfunction

  // A column access may follow another one only in the same direction.
  function automatic logic dir_ok(input logic last_v, input logic last_wr,
                                  input logic want_wr);
    dir_ok = !last_v || (last_wr == want_wr);
  endfunction

endpackage

// File: rtl/sbt_bank.sv
module sbt_bank
  import sbt_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int T_ACT = 3,
  parameter int T_PRE = 3,
  parameter int CW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [1:0]       op,
  input  logic             ap,
  input  logic [ROW_W-1:0] row,
  output logic             active,
  output logic             busy,
  output logic [ROW_W-1:0] row_q
);

  logic [CW-1:0] cnt;
  sbt_op_e       op_e;

  assign op_e = sbt_op_e'(op);
  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      row_q  <= '0;
      cnt    <= '0;
    end else if (hit) begin
      cnt <= CW'(occupancy(op_e, ap, T_ACT, T_PRE));
      case (op_e)
        OP_ACT: begin
          active <= 1'b1;
          row_q  <= row;
        end
        OP_PRE:  active <= 1'b0;
        default: if (ap) active <= 1'b0;
      endcase
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/sbt_bus.sv
module sbt_bus
  import sbt_pkg::*;
#(
  parameter int CL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic col_fire,
  input  logic col_wr,
  output logic rd_ok,
  output logic wr_ok,
  output logic rd_valid
);

  logic          last_v;
  logic          last_wr;
  logic [CL-1:0] pipe;

  assign rd_ok    = dir_ok(last_v, last_wr, 1'b0);
  assign wr_ok    = dir_ok(last_v, last_wr, 1'b1);
  assign rd_valid = pipe[CL-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_v  <= 1'b0;
      last_wr <= 1'b0;
      pipe    <= '0;
    end else begin
      last_v  <= col_fire;
      if (col_fire) last_wr <= col_wr;
      pipe[0] <= col_fire && !col_wr;
      for (int i = 1; i < CL; i++) pipe[i] <= pipe[i-1];
    end
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int NB    = 4,
  parameter int ROW_W = 12,
  parameter int T_ACT = 3,
  parameter int T_PRE = 3,
  parameter int CL    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [1:0]          cmd_bank,
  input  logic [ROW_W-1:0]    cmd_row,
  input  logic                cmd_autopre,
  output logic [NB-1:0]       can_act,
  output logic [NB-1:0]       can_pre,
  output logic [NB-1:0]       can_rd,
  output logic [NB-1:0]       can_wr,
  output logic [NB-1:0]       bank_active,
  output logic [NB*ROW_W-1:0] bank_row,
  output logic                rd_valid,
  output logic                cmd_err
);

  localparam int TMAX = (T_ACT > T_PRE) ? T_ACT : T_PRE;
  localparam int CW   = $clog2(TMAX + 1);

  sbt_op_e       op_e;
  logic [NB-1:0] bank_busy;
  logic [NB-1:0] bank_hit;
  logic          sel_ok;
  logic          legal;
  logic          act_fire, pre_fire, col_fire, rd_fire, col_is_wr;
  logic          rd_ok, wr_ok;

  assign op_e = sbt_op_e'(cmd_op);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sbt_bank #(
      .ROW_W(ROW_W), .T_ACT(T_ACT), .T_PRE(T_PRE), .CW(CW)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (bank_hit[b]),
      .op    (cmd_op),
      .ap    (cmd_autopre),
      .row   (cmd_row),
      .active(bank_active[b]),
      .busy  (bank_busy[b]),
      .row_q (bank_row[b*ROW_W +: ROW_W])
    );
    assign can_act[b]  = !bank_active[b] && !bank_busy[b];
    assign can_pre[b]  =  bank_active[b] && !bank_busy[b];
    assign can_rd[b]   =  bank_active[b] && !bank_busy[b] && rd_ok;
    assign can_wr[b]   =  bank_active[b] && !bank_busy[b] && wr_ok;
    assign bank_hit[b] = legal && (cmd_bank == b[1:0]);
  end

  always_comb begin
    case (op_e)
      OP_PRE:  sel_ok = can_pre[cmd_bank];
      OP_ACT:  sel_ok = can_act[cmd_bank];
      OP_RD:   sel_ok = can_rd[cmd_bank];
      default: sel_ok = can_wr[cmd_bank];
    endcase
  end

  assign legal     = cmd_valid && sel_ok;
  assign act_fire  = legal && (op_e == OP_ACT);
  assign pre_fire  = legal && (op_e == OP_PRE);
  assign col_fire  = legal && (op_e == OP_RD || op_e == OP_WR);
  assign col_is_wr = (op_e == OP_WR);
  assign rd_fire   = col_fire && !col_is_wr;

  sbt_bus #(.CL(CL)) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .col_fire(col_fire),
    .col_wr  (col_is_wr),
    .rd_ok   (rd_ok),
    .wr_ok   (wr_ok),
    .rd_valid(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_err <= 1'b0;
    else        cmd_err <= cmd_valid && !sel_ok;
  end

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
  parameter int NB    = 4,
  parameter int ROW_W = 12,
  parameter int CL    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic [1:0]          cmd_bank,
  input logic [NB-1:0]       can_act,
  input logic [NB-1:0]       can_rd,
  input logic [NB-1:0]       bank_active,
  input logic [NB*ROW_W-1:0] bank_row,
  input logic [NB-1:0]       bank_hit,
  input logic                legal,
  input logic                act_fire,
  input logic                pre_fire,
  input logic                col_fire,
  input logic                col_is_wr,
  input logic                rd_fire,
  input logic                rd_valid,
  input logic                cmd_err
);

  a_r9_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !legal) |=> cmd_err);

  a_r9_state_held: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (bank_active == $past(bank_active)) && (bank_row == $past(bank_row)));

  a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> bank_active[$past(cmd_bank)]);

  a_r3_act_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> !can_rd[$past(cmd_bank)]);

  a_r4_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    pre_fire |=> !bank_active[$past(cmd_bank)] && !can_act[$past(cmd_bank)]);

  a_r7_no_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (col_fire && $past(col_fire)) |-> (col_is_wr == $past(col_is_wr)));

  a_r5_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));

  if (CL == 3) begin : g_cl3
    a_r8_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> ##2 rd_valid);
  end

endmodule

bind sdram_bank_tracker sbt_checker #(.NB(NB), .ROW_W(ROW_W), .CL(CL)) u_chk (.*);

// File: tb/tb_sdram_bank_tracker.sv
module tb_sdram_bank_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [1:0]  cmd_bank = '0;
  logic [11:0] cmd_row = '0;
  logic        cmd_autopre = 1'b0;
  logic [3:0]  can_act, can_pre, can_rd, can_wr, bank_active;
  logic [47:0] bank_row;
  logic        rd_valid, cmd_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit err_pend = 1'b0;
  bit done = 1'b0;
  int rdq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_bank_tracker dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: one bus cycle per call; checks the flag and last cycle's error.
  task automatic step(input bit v, input logic [1:0] op, input logic [1:0] bank,
                      input logic [11:0] row, input bit ap, input bit exp_ok,
                      input string req);
    logic flag;
    @(negedge clk);
    check("R9 err strobe", 64'(cmd_err), 64'(err_pend));
    if (v) begin
      case (op)
        2'd0:    flag = can_pre[bank];
        2'd1:    flag = can_act[bank];
        2'd2:    flag = can_rd[bank];
        default: flag = can_wr[bank];
      endcase
      check(req, 64'(flag), 64'(exp_ok));
    end
    cmd_valid = v; cmd_op = op; cmd_bank = bank; cmd_row = row; cmd_autopre = ap;
    err_pend = v && !exp_ok;
    if (v && exp_ok && op == 2'd2) rdq.push_back(cyc + 3);
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 2'd0, 12'h0, 1'b0, 1'b0, "");
  endtask

  // Monitor: each read strobe must match the oldest expected cycle (R8).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rd_valid) begin
        if (rdq.size() == 0) check("R8 unexpected rd_valid", 64'(cyc), 64'hFFFF);
        else check("R8 rd_valid cycle", 64'(cyc), 64'(rdq.pop_front()));
      end else if (rdq.size() > 0 && rdq[0] == cyc) begin
        check("R8 missing rd_valid", 64'(0), 64'(1));
        void'(rdq.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle();
    check("R1 can_act", 64'(can_act), 64'hF);
    check("R1 can_pre", 64'(can_pre), 64'h0);
    check("R1 can_rd/wr", 64'({can_rd, can_wr}), 64'h0);
    check("R1 active", 64'(bank_active), 64'h0);
    check("R1 rd_valid", 64'(rd_valid), 64'h0);
    step(1'b1, 2'd1, 2'd0, 12'h123, 1'b0, 1'b1, "R2 act idle bank");
    idle();
    check("R2 active", 64'(bank_active), 64'h1);
    check("R2 row", 64'(bank_row[11:0]), 64'h123);
    check("R3 busy pre", 64'(can_pre[0]), 64'h0);
    check("R5 other bank", 64'(can_act[3:1]), 64'h7);
    step(1'b1, 2'd2, 2'd0, 12'h0, 1'b0, 1'b0, "R3 read at c+2");
    step(1'b1, 2'd2, 2'd0, 12'h0, 1'b0, 1'b1, "R3 read at c+3");
    check("R9 state kept", 64'(bank_active), 64'h1);
    step(1'b1, 2'd2, 2'd0, 12'h0, 1'b0, 1'b1, "R6 back-to-back read");
    step(1'b1, 2'd3, 2'd0, 12'h0, 1'b0, 1'b0, "R7 write after read");
    step(1'b1, 2'd3, 2'd0, 12'h0, 1'b0, 1'b1, "R7 write after bubble");
    step(1'b1, 2'd3, 2'd0, 12'h0, 1'b0, 1'b1, "R6 back-to-back write");
    step(1'b1, 2'd2, 2'd0, 12'h0, 1'b0, 1'b0, "R7 read after write");
    step(1'b1, 2'd1, 2'd0, 12'h456, 1'b0, 1'b0, "R2 act active bank");
    step(1'b1, 2'd0, 2'd0, 12'h0, 1'b0, 1'b1, "R4 pre active bank");
    check("R9 row kept", 64'(bank_row[11:0]), 64'h123);
    step(1'b1, 2'd1, 2'd1, 12'h0AB, 1'b0, 1'b1, "R5 act other bank");
    check("R4 idle", 64'(bank_active[0]), 64'h0);
    step(1'b1, 2'd1, 2'd0, 12'h0, 1'b0, 1'b0, "R4 act at c+2");
    step(1'b1, 2'd1, 2'd0, 12'hFFF, 1'b0, 1'b1, "R4 act at c+3");
    step(1'b1, 2'd2, 2'd1, 12'h0, 1'b1, 1'b1, "R10 read with autopre");
    idle();
    check("R10 bank idle", 64'(bank_active), 64'h1);
    check("R2 new row", 64'(bank_row[11:0]), 64'hFFF);
    check("R2 row bank1", 64'(bank_row[23:12]), 64'h0AB);
    idle();
    check("R10 busy c+2", 64'(can_act[1]), 64'h0);
    step(1'b1, 2'd1, 2'd1, 12'h0, 1'b0, 1'b0, "R10 act at c+3");
    step(1'b1, 2'd1, 2'd1, 12'h321, 1'b0, 1'b1, "R10 act at c+4");
    step(1'b1, 2'd0, 2'd2, 12'h0, 1'b0, 1'b0, "R4 pre idle bank");
    idle();
    check("R9 active after bad pre", 64'(bank_active), 64'h3);
    check("R2 row after act", 64'(bank_row[23:12]), 64'h321);
    repeat (5) idle();
    check("R8 all reads seen", 64'(rdq.size()), 64'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule